// File: doc/BRIEF.md
# Retry Backoff and Cooldown Throttle

This block stands between a recovery controller and whatever performs a recovery attempt after a protection event. Each time the controller pulses a request, the block either grants the attempt or refuses it with a reason code. A grant needs three things. The cooldown must have run out. The attempt budget for the current interval must be nonzero. The rail-stable and thermal-headroom flags must both be high. A refused request is dropped, not queued.

Every fault pulse is treated as a failed attempt. It raises the backoff level by one, up to a ceiling, and restarts the cooldown at the longer length for the new level. The cooldown for level L lasts BASE_CYC·2^L cycles. If an attempt runs for a qualification time after its grant with no fault, it counts as a success and the level drops back to zero.

A free-running interval timer reloads the attempt budget. This caps how many attempts can happen per interval, so a hot device cannot heat itself further through a tight retry loop. All pins are plain control and status signals. Requests are single-cycle pulses with no back-pressure, and every request gets exactly one answer pulse.

Top module: `retry_gate`

## Requirements
- R1: A request granted at a clock edge produces `grant` high for exactly the next cycle. Every request produces exactly one of `grant` or `deny` in the cycle after it is sampled, and the two are never high together.
- R2: After a grant or a fault sampled at edge E, a request sampled at edge E+k is refused with reason 0 (cooldown) when k ≤ BASE_CYC·2^L. L is the level used to load the cooldown: the current level for a grant, the new level for a fault. A request sampled together with a fault is also refused with reason 0.
- R3: With cooldown and budget clear, a request is refused with reason 2 when `rail_ok` is low, and with reason 3 when only `thermal_ok` is low. Rail is checked before thermal.
- R4: A fault pulse raises `backoff_lvl` by one, visible in the cycle after the fault is sampled.
- R5: `backoff_lvl` holds at MAX_EXP when further faults arrive.
- R6: When QUAL_CYC edges pass after a grant with no fault, `backoff_lvl` returns to 0 after edge grant+QUAL_CYC and not before.
- R7: Each grant lowers `budget_left` by one. A request that finds the budget at 0 is refused with reason 1. Refusal priority is: cooldown (0), then budget (1), then rail (2), then thermal (3).
- R8: A free-running timer reloads `budget_left` to MAX_ATT once every WIN_CYC cycles. A request after the reload can be granted again.
- R9: During and after reset, `grant` and `deny` are low, `backoff_lvl` is 0 and `budget_left` is MAX_ATT. The first request after reset needs no cooldown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Retry request pulse |
| fault | input | 1 | Protection event / failed attempt pulse |
| rail_ok | input | 1 | Supply rail stable |
| thermal_ok | input | 1 | Temperature headroom available |
| grant | output | 1 | Attempt granted, one-cycle pulse |
| deny | output | 1 | Request refused, one-cycle pulse |
| deny_code | output | 2 | Reason for the last refusal: 0 cooldown, 1 budget, 2 rail, 3 thermal |
| backoff_lvl | output | $clog2(MAX_EXP+1) | Current backoff level |
| budget_left | output | $clog2(MAX_ATT+1) | Attempts remaining in this interval |

## Verification
The answer pulse, either `grant` or `deny` with its code, is due one cycle after the edge that samples the request. The level and budget changes from a fault, a grant or a reload also appear one cycle after their edge. The success reset lands exactly QUAL_CYC edges after the grant. The bench drives every input at the falling edge. Before the edge that samples a request, the driver pushes the expected answer into a queue. A monitor pops that answer at the following falling edge and compares it, so each result is checked in the exact cycle it is due. Cooldown limits are hit at k = C and k = C+1 edges after their cause, and the success reset is checked one cycle before and at its due cycle.

// File: rtl/retry_gate_pkg.sv
package retry_gate_pkg;
  typedef enum logic [1:0] {
    WHY_COOL   = 2'd0,
    WHY_BUDGET = 2'd1,
    WHY_RAIL   = 2'd2,
    WHY_THERM  = 2'd3
  } deny_why_e;
endpackage

// File: rtl/retry_window.sv
module retry_window #(
  parameter int WIN_CYC = 4096,
  parameter int MAX_ATT = 4,
  localparam int WW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1,
  localparam int BW = $clog2(MAX_ATT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  output logic [BW-1:0] budget
);
  localparam logic [WW-1:0] WLAST = WW'(WIN_CYC - 1);
  localparam logic [BW-1:0] FULL  = BW'(MAX_ATT);

  logic [WW-1:0] win_cnt;
  logic          wrap;
  logic [BW-1:0] base;

  assign wrap = (win_cnt == WLAST);
  assign base = wrap ? FULL : budget;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_cnt <= '0;
      budget  <= FULL;
    end else begin
      win_cnt <= wrap ? '0 : win_cnt + 1'b1;
      budget  <= base - BW'(take);
    end
  end
endmodule

// File: rtl/retry_backoff.sv
module retry_backoff #(
  parameter int BASE_CYC = 16,
  parameter int MAX_EXP  = 4,
  parameter int QUAL_CYC = 64,
  localparam int LW = $clog2(MAX_EXP + 1),
  localparam int CW = $clog2((BASE_CYC << MAX_EXP) + 1),
  localparam int QW = $clog2(QUAL_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          fault,
  output logic          ready,
  output logic [LW-1:0] lvl
);
  localparam logic [LW-1:0] LTOP = LW'(MAX_EXP);

  logic [CW-1:0] cool_tab [MAX_EXP+1];
  logic [CW-1:0] cool_cnt;
  logic [QW-1:0] qual_cnt;
  logic          qual_on;
  logic [LW-1:0] lvl_up;

  for (genvar g = 0; g <= MAX_EXP; g++) begin : g_tab
    assign cool_tab[g] = CW'(BASE_CYC << g);
  end

  assign lvl_up = (lvl == LTOP) ? lvl : lvl + 1'b1;
  assign ready  = (cool_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl      <= '0;
      cool_cnt <= '0;
      qual_cnt <= '0;
      qual_on  <= 1'b0;
    end else if (fault) begin
      lvl      <= lvl_up;
      cool_cnt <= cool_tab[lvl_up];
      qual_on  <= 1'b0;
    end else if (take) begin
      cool_cnt <= cool_tab[lvl];
      qual_cnt <= QW'(QUAL_CYC);
      qual_on  <= 1'b1;
    end else begin
      if (cool_cnt != '0) cool_cnt <= cool_cnt - 1'b1;
      if (qual_on) begin
        if (qual_cnt == QW'(1)) begin
          qual_on <= 1'b0;
          lvl     <= '0;
        end else begin
          qual_cnt <= qual_cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/retry_decide.sv
module retry_decide
  import retry_gate_pkg::*;
#(
  parameter int BW = 3
) (
  input  logic          req,
  input  logic          fault,
  input  logic          ready,
  input  logic [BW-1:0] budget,
  input  logic          rail_ok,
  input  logic          thermal_ok,
  output logic          take,
  output deny_why_e     why
);
  always_comb begin
    take = 1'b0;
    why  = WHY_COOL;
    if (req) begin
      if (fault || !ready)     why = WHY_COOL;
      else if (budget == '0)   why = WHY_BUDGET;
      else if (!rail_ok)       why = WHY_RAIL;
      else if (!thermal_ok)    why = WHY_THERM;
      else                     take = 1'b1;
    end
  end
endmodule

// File: rtl/retry_gate.sv
module retry_gate
  import retry_gate_pkg::*;
#(
  parameter int BASE_CYC = 16,
  parameter int MAX_EXP  = 4,
  parameter int QUAL_CYC = 64,
  parameter int WIN_CYC  = 4096,
  parameter int MAX_ATT  = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req,
  input  logic                           fault,
  input  logic                           rail_ok,
  input  logic                           thermal_ok,
  output logic                           grant,
  output logic                           deny,
  output logic [1:0]                     deny_code,
  output logic [$clog2(MAX_EXP+1)-1:0]   backoff_lvl,
  output logic [$clog2(MAX_ATT+1)-1:0]   budget_left
);
  localparam int BW = $clog2(MAX_ATT + 1);

  logic      ready;
  logic      take;
  deny_why_e why;

  retry_window #(.WIN_CYC(WIN_CYC), .MAX_ATT(MAX_ATT)) u_win (
    .clk(clk), .rst_n(rst_n), .take(take), .budget(budget_left)
  );

  retry_backoff #(.BASE_CYC(BASE_CYC), .MAX_EXP(MAX_EXP), .QUAL_CYC(QUAL_CYC)) u_bo (
    .clk(clk), .rst_n(rst_n), .take(take), .fault(fault),
    .ready(ready), .lvl(backoff_lvl)
  );

  retry_decide #(.BW(BW)) u_dec (
    .req(req), .fault(fault), .ready(ready), .budget(budget_left),
    .rail_ok(rail_ok), .thermal_ok(thermal_ok), .take(take), .why(why)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant     <= 1'b0;
      deny      <= 1'b0;
      deny_code <= 2'd0;
    end else begin
      grant <= take;
      deny  <= req && !take;
      if (req && !take) deny_code <= why;
    end
  end
endmodule

// File: rtl/retry_gate_chk.sv
module retry_gate_chk #(
  parameter int MAX_EXP = 4,
  parameter int LW = 3,
  parameter int BW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic          fault,
  input logic          rail_ok,
  input logic          thermal_ok,
  input logic          grant,
  input logic          deny,
  input logic [LW-1:0] backoff_lvl,
  input logic [BW-1:0] budget_left
);
  p_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && deny));

  p_answer_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(req)) |-> (grant || deny));

  p_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> !grant);

  p_fault_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fault) |-> !grant);

  p_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> ($past(rail_ok) && $past(thermal_ok)));

  p_bump_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(fault) && ($past(backoff_lvl) < LW'(MAX_EXP)))
      |-> (backoff_lvl == $past(backoff_lvl) + 1'b1));

  p_ceiling_r5: assert property (@(posedge clk) disable iff (!rst_n)
    backoff_lvl <= LW'(MAX_EXP));

  p_budget_r7: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> ($past(budget_left) != '0));
endmodule

bind retry_gate retry_gate_chk #(
  .MAX_EXP(MAX_EXP), .LW($clog2(MAX_EXP+1)), .BW($clog2(MAX_ATT+1))
) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .fault(fault), .rail_ok(rail_ok),
  .thermal_ok(thermal_ok), .grant(grant), .deny(deny),
  .backoff_lvl(backoff_lvl), .budget_left(budget_left)
);

// File: tb/retry_gate_bench.sv
`timescale 1ns/1ps
module retry_gate_bench;
  localparam int BASE_CYC = 4;
  localparam int MAX_EXP  = 2;
  localparam int QUAL_CYC = 10;
  localparam int WIN_CYC  = 600;
  localparam int MAX_ATT  = 4;

  typedef struct {
    bit         g;
    logic [1:0] code;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, fault = 1'b0, rail_ok = 1'b1, thermal_ok = 1'b1;
  logic grant, deny;
  logic [1:0] deny_code;
  logic [1:0] backoff_lvl;
  logic [2:0] budget_left;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  exp_t q[$];

  always #10 clk = ~clk;

  retry_gate #(.BASE_CYC(BASE_CYC), .MAX_EXP(MAX_EXP), .QUAL_CYC(QUAL_CYC),
               .WIN_CYC(WIN_CYC), .MAX_ATT(MAX_ATT)) u_retry_gate (
    .clk(clk), .rst_n(rst_n), .req(req), .fault(fault), .rail_ok(rail_ok),
    .thermal_ok(thermal_ok), .grant(grant), .deny(deny), .deny_code(deny_code),
    .backoff_lvl(backoff_lvl), .budget_left(budget_left)
  );

  task automatic chk(bit ok, string tag, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_ans(bit g, logic [1:0] code, string tag);
    exp_t e;
    e.g = g; e.code = code; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic pulse_req(bit with_fault);
    req = 1'b1; fault = with_fault;
    @(negedge clk);
    req = 1'b0; fault = 1'b0;
  endtask

  task automatic pulse_fault();
    fault = 1'b1;
    @(negedge clk);
    fault = 1'b0;
  endtask

  // monitor: pops the expected answer for each result pulse
  always @(negedge clk) begin
    if (rst_n && (grant || deny)) begin
      if (q.size() == 0) begin
        chk(1'b0, "R1 unexpected answer pulse", {grant, deny}, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (e.g)
          chk(grant && !deny, {e.tag, " grant"}, {grant, deny}, 2);
        else
          chk(deny && !grant && deny_code == e.code, {e.tag, " deny code"},
              deny ? int'(deny_code) : -1, int'(e.code));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    idle(3);
    chk(grant == 0 && deny == 0, "R9 pulses low in reset", {grant, deny}, 0);
    rst_n = 1'b1;
    idle(1);
    chk(grant == 0 && deny == 0, "R9 pulses low after reset", {grant, deny}, 0);
    chk(backoff_lvl == 0, "R9 level", backoff_lvl, 0);
    chk(budget_left == 3'(MAX_ATT), "R9 budget", budget_left, MAX_ATT);

    // first request needs no cooldown
    expect_ans(1, 2'd0, "R9 first request");
    pulse_req(0);                               // edge E
    chk(budget_left == 3, "R7 budget after grant", budget_left, 3);
    expect_ans(0, 2'd0, "R2 request in cooldown");
    pulse_req(0);                               // E+1
    idle(1);
    pulse_fault();                              // F, level 1, cooldown 8
    chk(backoff_lvl == 1, "R4 level after fault", backoff_lvl, 1);
    idle(7);
    expect_ans(0, 2'd0, "R2 k=C still cooling");
    pulse_req(0);                               // F+8
    expect_ans(1, 2'd0, "R2 k=C+1 granted");
    pulse_req(0);                               // F+9
    chk(budget_left == 2, "R7 budget second grant", budget_left, 2);
    pulse_fault();                              // level 2, cooldown 16
    chk(backoff_lvl == 2, "R4 level second fault", backoff_lvl, 2);
    pulse_fault();                              // ceiling
    chk(backoff_lvl == 2, "R5 level at ceiling", backoff_lvl, 2);
    idle(15);
    expect_ans(0, 2'd0, "R2 k=16 at top level");
    pulse_req(0);
    expect_ans(1, 2'd0, "R2 k=17 granted");
    pulse_req(0);                               // G3
    idle(QUAL_CYC - 1);
    chk(backoff_lvl == 2, "R6 level before qualification", backoff_lvl, 2);
    idle(1);
    chk(backoff_lvl == 0, "R6 level after success", backoff_lvl, 0);
    idle(8);

    rail_ok = 1'b0;
    expect_ans(0, 2'd2, "R3 rail low");
    pulse_req(0);
    rail_ok = 1'b1; thermal_ok = 1'b0;
    expect_ans(0, 2'd3, "R3 thermal low");
    pulse_req(0);
    rail_ok = 1'b0;
    expect_ans(0, 2'd2, "R3 rail before thermal");
    pulse_req(0);
    rail_ok = 1'b1; thermal_ok = 1'b1;
    expect_ans(1, 2'd0, "R3 both flags high");
    pulse_req(0);
    chk(budget_left == 0, "R7 budget exhausted", budget_left, 0);
    idle(5);
    expect_ans(0, 2'd1, "R7 budget empty");
    pulse_req(0);
    rail_ok = 1'b0;
    expect_ans(0, 2'd1, "R7 budget before rail");
    pulse_req(0);
    rail_ok = 1'b1;
    chk(budget_left == 0, "R7 refused requests use no budget", budget_left, 0);

    begin
      bit seen = 0;
      for (int i = 0; i < WIN_CYC + 10 && !seen; i++) begin
        @(negedge clk);
        if (budget_left == 3'(MAX_ATT)) seen = 1;
      end
      chk(seen, "R8 budget reload", budget_left, MAX_ATT);
    end
    expect_ans(1, 2'd0, "R8 grant after reload");
    pulse_req(0);
    chk(budget_left == 3, "R8 budget after reload grant", budget_left, 3);
    idle(6);
    expect_ans(0, 2'd0, "R2 fault same edge");
    pulse_req(1);
    chk(backoff_lvl == 1, "R4 level after same-edge fault", backoff_lvl, 1);
    idle(3);
    chk(q.size() == 0, "R1 all answers seen", q.size(), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule